// File: doc/BRIEF.md
# Frame line-count lock tracker

This block follows the frame structure of an incoming video signal. It takes one-cycle horizontal and vertical sync pulses and counts the horizontal pulses between two vertical pulses. It then runs an internal line counter whose frame length follows that count. An input with 524 lines per frame therefore gives a 524-line internal frame, and an input of 525 lines gives 525.

Whenever the measured count moves away from the adopted length, the block takes the new length and drops its lock flag. It raises the flag again only after a pull-in run of consecutive frames that agree with that length. If vertical sync stops arriving, a watchdog on the line count clears lock. The internal counter then keeps running at the last adopted length.

All pins are plain control and status signals. The sync inputs are single-cycle strobes in the block's clock domain, so no valid/ready handshake is used and nothing is ever back-pressured. The outputs update every cycle.

Top module: `frame_lock_tracker`

## Requirements
- R1: While reset is applied and in the first cycle after it, `locked` is 0, `frame_len` equals DEFAULT_LINES (525 by default), `line_num` is 0 and `frame_start` is 0.
- R2: A measurement is the number of `hsync_pulse` strobes seen strictly between two `vsync_pulse` strobes. An `hsync_pulse` in the same cycle as a `vsync_pulse` counts toward the new frame. The first `vsync_pulse` after reset, or after a watchdog trip, only sets the reference and yields no measurement.
- R3: A measurement of at least MIN_LINES that differs from `frame_len` becomes the new `frame_len` in the cycle after the vertical strobe. In that same cycle `locked` reads 0 and the pull-in run restarts from zero.
- R4: `locked` rises in the cycle after the PULL_IN-th consecutive measurement equal to `frame_len` (4 by default). It stays 1 while further measurements keep matching.
- R5: A measurement below MIN_LINES leaves `frame_len` unchanged, clears `locked` and restarts the pull-in run.
- R6: TIMEOUT_LINES horizontal strobes without a vertical strobe clear `locked`, restart the pull-in run and discard the reference. `frame_len` is kept and `line_num` keeps counting. A frame of TIMEOUT_LINES-1 lines is still a valid measurement.
- R7: Each `hsync_pulse` advances `line_num` by one. When `line_num` is at `frame_len`-1 it wraps to 0 instead, and `frame_start` is 1 for exactly the cycle in which `line_num` first shows 0.
- R8: A `vsync_pulse` seen while `locked` is 0, or while `line_num` is not 0, forces `line_num` to 0 with a `frame_start` pulse. If `locked` is 1 and `line_num` is already 0, there is no extra pulse.
- R9: `line_num` is always less than `frame_len`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_pulse | input | 1 | One-cycle strobe per input line |
| vsync_pulse | input | 1 | One-cycle strobe per input frame |
| line_num | output | LINE_W | Internal line number |
| frame_start | output | 1 | One-cycle pulse when `line_num` returns to 0 |
| frame_len | output | LINE_W | Adopted lines per frame |
| locked | output | 1 | Frame structure lock status |

## Verification
The bench builds the block with LINE_W 8, DEFAULT_LINES 20, MIN_LINES 8, TIMEOUT_LINES 64 and PULL_IN 4. These short frames make each of the following cost only a few hundred cycles: a full pull-in, a length change, a runt frame, a watchdog trip, and a frame of exactly TIMEOUT_LINES-1 lines. A vertical strobe that coincides with a horizontal strobe is also driven. The expected lock and length for every vertical strobe come from a model in the driver, and a monitor compares them one cycle later.

// File: rtl/flt_pkg.sv
package flt_pkg;
  typedef enum logic [1:0] {
    MEAS_NONE  = 2'd0,
    MEAS_MATCH = 2'd1,
    MEAS_ADOPT = 2'd2,
    MEAS_RUNT  = 2'd3
  } meas_kind_e;
endpackage

// File: rtl/flt_line_meter.sv
module flt_line_meter #(
  parameter int LINE_W        = 11,
  parameter int TIMEOUT_LINES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_pulse,
  input  logic              vsync_pulse,
  output logic              meas_valid,
  output logic [LINE_W-1:0] meas_lines,
  output logic              timeout
);
  localparam logic [LINE_W-1:0] LAST_CNT = LINE_W'(TIMEOUT_LINES - 1);

  logic [LINE_W-1:0] cnt_q;
  logic              have_ref_q;

  assign meas_valid = vsync_pulse & have_ref_q;
  assign meas_lines = cnt_q;
  assign timeout    = hsync_pulse & ~vsync_pulse & (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
    end else if (vsync_pulse) begin
      cnt_q      <= hsync_pulse ? LINE_W'(1) : '0;
      have_ref_q <= 1'b1;
    end else if (timeout) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
    end else if (hsync_pulse) begin
      cnt_q      <= cnt_q + LINE_W'(1);
    end
  end

  // R6: the running count never reaches the watchdog limit
  p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT);

  // R6: a watchdog trip leaves no reference for the next vertical strobe
  p_trip_drops_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !have_ref_q);
endmodule

// File: rtl/flt_lock_ctrl.sv
module flt_lock_ctrl
  import flt_pkg::*;
#(
  parameter int LINE_W        = 11,
  parameter int DEFAULT_LINES = 525,
  parameter int MIN_LINES     = 16,
  parameter int PULL_IN       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_valid,
  input  logic [LINE_W-1:0] meas_lines,
  input  logic              timeout,
  output logic [LINE_W-1:0] frame_len,
  output logic              locked
);
  localparam int            MW         = (PULL_IN > 1) ? $clog2(PULL_IN) : 1;
  localparam logic [MW-1:0] LAST_MATCH = MW'(PULL_IN - 1);
  localparam logic [LINE_W-1:0] MIN_LEN = LINE_W'(MIN_LINES);

  logic [LINE_W-1:0] len_q;
  logic [MW-1:0]     match_q;
  logic              lock_q;
  meas_kind_e        kind;

  always_comb begin
    kind = MEAS_NONE;
    if (meas_valid) begin
      if (meas_lines < MIN_LEN)      kind = MEAS_RUNT;
      else if (meas_lines == len_q)  kind = MEAS_MATCH;
      else                           kind = MEAS_ADOPT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= LINE_W'(DEFAULT_LINES);
      match_q <= '0;
      lock_q  <= 1'b0;
    end else if (timeout) begin
      match_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      case (kind)
        MEAS_MATCH: begin
          if (match_q == LAST_MATCH) lock_q <= 1'b1;
          else                       match_q <= match_q + MW'(1);
        end
        MEAS_ADOPT: begin
          len_q   <= meas_lines;
          match_q <= '0;
          lock_q  <= 1'b0;
        end
        MEAS_RUNT: begin
          match_q <= '0;
          lock_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign frame_len = len_q;
  assign locked    = lock_q;

  // R3: an adopted length shows up unlocked one cycle later
  p_adopt_unlocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == MEAS_ADOPT) |=> (!locked && frame_len == $past(meas_lines)));

  // R4: lock only rises right after a measurement
  p_lock_on_meas_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_valid));

  // R5: a runt measurement never changes the length
  p_runt_keeps_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == MEAS_RUNT) |=> ($stable(frame_len) && !locked));
endmodule

// File: rtl/flt_line_gen.sv
module flt_line_gen #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_pulse,
  input  logic              vsync_pulse,
  input  logic              locked,
  input  logic [LINE_W-1:0] frame_len,
  output logic [LINE_W-1:0] line_num,
  output logic              frame_start
);
  localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

  logic [LINE_W-1:0] line_q;
  logic              start_q;
  logic              resync;

  assign resync = vsync_pulse & (~locked | (line_q != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (resync) begin
        line_q  <= '0;
        start_q <= 1'b1;
      end else if (hsync_pulse) begin
        if (line_q >= frame_len - ONE) begin
          line_q  <= '0;
          start_q <= 1'b1;
        end else begin
          line_q  <= line_q + ONE;
        end
      end
    end
  end

  assign line_num    = line_q;
  assign frame_start = start_q;

  // R7: a frame-start pulse always coincides with line zero
  p_start_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_num == '0));

  // R8: a vertical strobe while unlocked realigns the counter
  p_resync_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_pulse && !locked) |=> (frame_start && line_num == '0));
endmodule

// File: rtl/frame_lock_tracker.sv
module frame_lock_tracker #(
  parameter int LINE_W        = 11,
  parameter int DEFAULT_LINES = 525,
  parameter int MIN_LINES     = 16,
  parameter int TIMEOUT_LINES = 1024,
  parameter int PULL_IN       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_pulse,
  input  logic              vsync_pulse,
  output logic [LINE_W-1:0] line_num,
  output logic              frame_start,
  output logic [LINE_W-1:0] frame_len,
  output logic              locked
);
  logic              meas_valid;
  logic [LINE_W-1:0] meas_lines;
  logic              timeout;

  flt_line_meter #(
    .LINE_W        (LINE_W),
    .TIMEOUT_LINES (TIMEOUT_LINES)
  ) u_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_pulse (hsync_pulse),
    .vsync_pulse (vsync_pulse),
    .meas_valid  (meas_valid),
    .meas_lines  (meas_lines),
    .timeout     (timeout)
  );

  flt_lock_ctrl #(
    .LINE_W        (LINE_W),
    .DEFAULT_LINES (DEFAULT_LINES),
    .MIN_LINES     (MIN_LINES),
    .PULL_IN       (PULL_IN)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .meas_lines (meas_lines),
    .timeout    (timeout),
    .frame_len  (frame_len),
    .locked     (locked)
  );

  flt_line_gen #(
    .LINE_W (LINE_W)
  ) u_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_pulse (hsync_pulse),
    .vsync_pulse (vsync_pulse),
    .locked      (locked),
    .frame_len   (frame_len),
    .line_num    (line_num),
    .frame_start (frame_start)
  );

  // R9: the internal line stays inside the adopted frame
  p_line_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_num < frame_len);

  // R3: the length never moves while lock is reported
  p_len_change_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_len) |-> !locked);

  // R6: a watchdog trip clears lock on the next cycle
  p_trip_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !locked);
endmodule

// File: tb/frame_lock_tracker_bench.sv
module frame_lock_tracker_bench;
  localparam int LW   = 8;
  localparam int DEF  = 20;
  localparam int MINL = 8;
  localparam int TMO  = 64;
  localparam int PULL = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          hs = 1'b0;
  logic          vs = 1'b0;
  logic [LW-1:0] line_num;
  logic          frame_start;
  logic [LW-1:0] frame_len;
  logic          locked;

  frame_lock_tracker #(
    .LINE_W (LW), .DEFAULT_LINES (DEF), .MIN_LINES (MINL),
    .TIMEOUT_LINES (TMO), .PULL_IN (PULL)
  ) u_frame_lock_tracker (
    .clk (clk), .rst_n (rst_n), .hsync_pulse (hs), .vsync_pulse (vs),
    .line_num (line_num), .frame_start (frame_start),
    .frame_len (frame_len), .locked (locked)
  );

  typedef struct packed {
    logic          lk;
    logic [LW-1:0] len;
    logic          rs;
  } exp_t;

  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  int   r9_bad = 0;

  int m_cnt = 0;
  bit m_ref = 0;
  int m_len = DEF;
  int m_match = 0;
  bit m_lock = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_line();
    @(negedge clk);
    hs = 1'b1;
    m_cnt++;
    if (m_cnt == TMO) begin
      m_lock = 0; m_match = 0; m_ref = 0; m_cnt = 0;
    end
    @(negedge clk);
    hs = 1'b0;
  endtask

  task automatic do_vsync(input bit with_h);
    exp_t it;
    @(negedge clk);
    vs = 1'b1;
    hs = with_h;
    it.rs = !m_lock;
    if (m_ref) begin
      if (m_cnt < MINL) begin
        m_lock = 0; m_match = 0;
      end else if (m_cnt == m_len) begin
        if (m_match == PULL - 1) m_lock = 1;
        else m_match++;
      end else begin
        m_len = m_cnt; m_lock = 0; m_match = 0;
      end
    end
    m_ref = 1;
    m_cnt = with_h ? 1 : 0;
    it.lk  = m_lock;
    it.len = LW'(m_len);
    q.push_back(it);
    @(negedge clk);
    vs = 1'b0;
    hs = 1'b0;
  endtask

  task automatic frame(input int n);
    repeat (n) do_line();
    do_vsync(1'b0);
  endtask

  // monitor: scoreboard pop one cycle after each vertical strobe
  logic vs_d = 1'b0;
  always @(posedge clk) vs_d <= vs;

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && line_num >= frame_len) r9_bad++;
    if (vs_d) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", "response without queued item", 0, 1);
      end else begin
        e = q.pop_front();
        check(locked == e.lk, "R4", "lock after vsync", int'(locked), int'(e.lk));
        check(frame_len == e.len, "R3", "length after vsync", int'(frame_len), int'(e.len));
        if (e.rs)
          check(line_num == '0 && frame_start, "R8", "resync line while unlocked",
                int'(line_num), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(locked == 1'b0, "R1", "reset lock", int'(locked), 0);
    check(frame_len == LW'(DEF), "R1", "reset length", int'(frame_len), DEF);
    check(line_num == '0, "R1", "reset line", int'(line_num), 0);
    check(frame_start == 1'b0, "R1", "reset frame_start", int'(frame_start), 0);

    // reference strobe, then pull-in at the default length
    do_vsync(1'b0);
    repeat (3) frame(DEF);
    check(locked == 1'b0, "R4", "no lock before pull-in ends", int'(locked), 0);
    frame(DEF);
    check(locked == 1'b1, "R4", "lock after four matches", int'(locked), 1);

    // internal wrap
    repeat (DEF - 1) do_line();
    check(line_num == LW'(DEF - 1), "R7", "last line before wrap", int'(line_num), DEF - 1);
    check(frame_start == 1'b0, "R7", "no pulse mid-frame", int'(frame_start), 0);
    do_line();
    check(line_num == '0 && frame_start, "R7", "wrap to line 0 with pulse", int'(line_num), 0);
    do_vsync(1'b0);
    check(frame_start == 1'b0, "R8", "no extra pulse when aligned", int'(frame_start), 0);

    // length change 20 -> 19
    frame(19);
    check(line_num == '0 && frame_start, "R8", "resync on mismatched frame", int'(line_num), 0);
    check(frame_len == LW'(19), "R3", "adopted new length", int'(frame_len), 19);
    repeat (3) frame(19);
    check(locked == 1'b0, "R4", "still pulling in", int'(locked), 0);
    frame(19);
    check(locked == 1'b1, "R4", "relocked at 19", int'(locked), 1);

    // coincident hsync and vsync
    repeat (19) do_line();
    do_vsync(1'b1);
    repeat (18) do_line();
    do_vsync(1'b0);
    check(locked == 1'b1 && frame_len == LW'(19), "R2", "coincident strobe counted in new frame",
          int'(frame_len), 19);

    // runt frame
    frame(3);
    check(frame_len == LW'(19), "R5", "runt keeps length", int'(frame_len), 19);
    check(locked == 1'b0, "R5", "runt drops lock", int'(locked), 0);
    repeat (3) frame(19);
    check(locked == 1'b0, "R5", "pull-in restarted", int'(locked), 0);
    frame(19);
    check(locked == 1'b1, "R5", "relocked after runt", int'(locked), 1);

    // watchdog
    repeat (70) do_line();
    check(locked == 1'b0, "R6", "watchdog drops lock", int'(locked), 0);
    check(frame_len == LW'(19), "R6", "watchdog keeps length", int'(frame_len), 19);
    check(line_num == LW'(70 % 19), "R6", "free-running line", int'(line_num), 70 % 19);
    do_vsync(1'b0);
    repeat (3) frame(19);
    check(locked == 1'b0, "R6", "reference only after trip", int'(locked), 0);
    frame(19);
    check(locked == 1'b1, "R6", "relocked after trip", int'(locked), 1);

    // longest valid frame, then one line more
    frame(TMO - 1);
    check(frame_len == LW'(TMO - 1), "R6", "limit-1 frame adopted", int'(frame_len), TMO - 1);
    repeat (4) frame(TMO - 1);
    check(locked == 1'b1, "R6", "lock at limit-1 length", int'(locked), 1);
    frame(TMO);
    check(locked == 1'b0 && frame_len == LW'(TMO - 1), "R6", "limit frame trips watchdog",
          int'(locked), 0);

    repeat (2) @(negedge clk);
    check(r9_bad == 0, "R9", "line below length cycles violated", r9_bad, 0);
    check(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule